// File: doc/BRIEF.md
# Native I/O Bit-Slice Reset Sequencer

This block brings a group of native-mode I/O bit slices and their slice controller out of reset in a fixed order, with a programmable gap between steps. Once the clock generator reports lock (passed through a multi-flop synchronizer), it releases three reset groups in turn: the slice delay lines, the slices themselves, and the slice controller. It then enables the high-speed PHY clock. Next it waits until the controller reports both delay-ready and compensation-ready. After one more gap it releases the application reset.

The voltage/temperature compensation enable is driven high from reset and throughout the sequence. A host may request it low, but the request takes effect only once the sequence has finished. A runtime reset request asserts every reset group at once and drops the PHY clock enable. When the request is withdrawn, the release sequence runs again without waiting for lock.

Top module: `io_rst_seq`

## Requirements
- R1: Out of rst_n, and until the synchronized lock flag is seen, the outputs are dly_rst_o=1, slc_rst_o=1, ctl_rst_o=1, phy_clk_en_o=0, cmp_en_o=1 and app_rst_o=1.
- R2: lock_async passes through SYNC_STAGES flip-flops. When lock_async is raised just after a falling edge, dly_rst_o is low at the falling edge SYNC_STAGES+GAP_CYCLES+1 cycles later.
- R3: The reset groups release in the order dly_rst_o, then slc_rst_o, then ctl_rst_o, each GAP_CYCLES cycles after the previous one. A later group is never released while an earlier group is still asserted.
- R4: phy_clk_en_o is low whenever any reset group is asserted. It rises GAP_CYCLES cycles after ctl_rst_o falls.
- R5: app_rst_o falls GAP_CYCLES+1 cycles after both dly_rdy and cmp_rdy are sampled high together while the PHY clock is enabled. One ready flag alone never releases it.
- R6: cmp_en_o is high whenever any reset group or app_rst_o is asserted.
- R7: cmp_off_req takes effect only after app_rst_o has been released. In that case cmp_en_o goes low one cycle after the request is sampled and returns high one cycle after it is withdrawn. At any other time the request has no effect.
- R8: One cycle after sys_rst is sampled high (outside the wait for lock), all three reset groups and app_rst_o are asserted, phy_clk_en_o is low and cmp_en_o is high. They stay that way while sys_rst stays high.
- R9: After a runtime reset, dly_rst_o falls GAP_CYCLES cycles after sys_rst is driven low, whatever the state of lock_async. The rest of the sequence then follows R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (from a clock-generator output) |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| lock_async | input | 1 | Clock-generator lock flag, asynchronous |
| sys_rst | input | 1 | Runtime reset request, active high, synchronous |
| dly_rdy | input | 1 | Delay-ready flag from the slice controller |
| cmp_rdy | input | 1 | Compensation-ready flag from the slice controller |
| cmp_off_req | input | 1 | Host request to drop the compensation enable |
| dly_rst_o | output | 1 | Reset for the slice delay lines |
| slc_rst_o | output | 1 | Reset for the bit slices |
| ctl_rst_o | output | 1 | Reset for the slice controller |
| phy_clk_en_o | output | 1 | Enable for the high-speed PHY clock output |
| cmp_en_o | output | 1 | Voltage/temperature compensation enable |
| app_rst_o | output | 1 | Application reset |

## Verification
The power-up sequence is driven twice. In one run the ready flags are raised only well after the PHY clock is enabled. In the other they are already high when it turns on. This separates "waits for ready" from "waits only for the gap". A directed case raises a single ready flag to show that both are needed. Random runtime resets of random length, some with the lock flag low, confirm that the restart ignores lock and repeats the exact spacing. A reset injected in the middle of the sequence shows that any step can be abandoned. Host requests to drop compensation are sent both before and after the application is released, so an early honour of the request would be seen.

// File: rtl/io_rst_pkg.sv
package io_rst_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_LOCK,
    ST_HOLD,
    ST_DLY_OFF,
    ST_SLC_OFF,
    ST_CTL_OFF,
    ST_PHY_ON,
    ST_APP_DLY,
    ST_RUN
  } seq_st_e;

  typedef struct packed {
    logic dly_rst;
    logic slc_rst;
    logic ctl_rst;
    logic phy_en;
    logic cmp_en;
    logic app_rst;
  } seq_out_t;

  localparam seq_out_t OUT_RESET = '{dly_rst: 1'b1, slc_rst: 1'b1, ctl_rst: 1'b1,
                                     phy_en: 1'b0, cmp_en: 1'b1, app_rst: 1'b1};

  // Output pattern held while a given state is current.
  function automatic seq_out_t decode(seq_st_e s);
    seq_out_t o;
    o = OUT_RESET;
    case (s)
      ST_DLY_OFF: o.dly_rst = 1'b0;
      ST_SLC_OFF: begin
        o.dly_rst = 1'b0;
        o.slc_rst = 1'b0;
      end
      ST_CTL_OFF: begin
        o.dly_rst = 1'b0;
        o.slc_rst = 1'b0;
        o.ctl_rst = 1'b0;
      end
      ST_PHY_ON, ST_APP_DLY: begin
        o.dly_rst = 1'b0;
        o.slc_rst = 1'b0;
        o.ctl_rst = 1'b0;
        o.phy_en  = 1'b1;
      end
      ST_RUN: begin
        o.dly_rst = 1'b0;
        o.slc_rst = 1'b0;
        o.ctl_rst = 1'b0;
        o.phy_en  = 1'b1;
        o.app_rst = 1'b0;
      end
      default: o = OUT_RESET;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/io_rst_sync.sv
module io_rst_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("io_rst_sync: STAGES must be at least 2");
    end
  endgenerate

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/io_rst_gap.sv
module io_rst_gap #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic done
);
  localparam int W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [W-1:0] LAST = W'(GAP - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clear || (cnt_q != LAST);
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/io_rst_fsm.sv
module io_rst_fsm
  import io_rst_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lock_sync,
  input  logic    sys_rst,
  input  logic    rdy_both,
  input  logic    gap_done,
  output seq_st_e state_q,
  output seq_st_e state_nxt,
  output logic    gap_clear
);
  always_comb begin
    state_nxt = state_q;
    if (sys_rst && (state_q != ST_WAIT_LOCK)) begin
      state_nxt = ST_HOLD;
    end else begin
      case (state_q)
        ST_WAIT_LOCK: if (lock_sync) state_nxt = ST_HOLD;
        ST_HOLD:      if (gap_done)  state_nxt = ST_DLY_OFF;
        ST_DLY_OFF:   if (gap_done)  state_nxt = ST_SLC_OFF;
        ST_SLC_OFF:   if (gap_done)  state_nxt = ST_CTL_OFF;
        ST_CTL_OFF:   if (gap_done)  state_nxt = ST_PHY_ON;
        ST_PHY_ON:    if (rdy_both)  state_nxt = ST_APP_DLY;
        ST_APP_DLY:   if (gap_done)  state_nxt = ST_RUN;
        ST_RUN:                      state_nxt = ST_RUN;
        default:                     state_nxt = ST_WAIT_LOCK;
      endcase
    end
  end

  // Every step starts its gap afresh; a held runtime reset keeps it at zero.
  assign gap_clear = (state_nxt != state_q) || sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_LOCK;
    else        state_q <= state_nxt;
  end
endmodule

// File: rtl/io_rst_outreg.sv
module io_rst_outreg
  import io_rst_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  seq_st_e  state_nxt,
  input  logic     cmp_off_req,
  output seq_out_t out_q
);
  seq_out_t out_d;

  always_comb begin
    out_d = decode(state_nxt);
    // Host may drop compensation only once the sequence has completed.
    if (state_nxt == ST_RUN) out_d.cmp_en = !cmp_off_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= OUT_RESET;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/io_rst_seq.sv
module io_rst_seq
  import io_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int GAP_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  input  logic sys_rst,
  input  logic dly_rdy,
  input  logic cmp_rdy,
  input  logic cmp_off_req,
  output logic dly_rst_o,
  output logic slc_rst_o,
  output logic ctl_rst_o,
  output logic phy_clk_en_o,
  output logic cmp_en_o,
  output logic app_rst_o
);
  logic     lock_sync;
  logic     gap_done;
  logic     gap_clear;
  logic     rdy_both;
  seq_st_e  state_q;
  seq_st_e  state_nxt;
  seq_out_t out_q;

  assign rdy_both = dly_rdy && cmp_rdy;

  io_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(lock_async), .q_sync(lock_sync)
  );

  io_rst_gap #(.GAP(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(gap_clear), .done(gap_done)
  );

  io_rst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .lock_sync(lock_sync), .sys_rst(sys_rst),
    .rdy_both(rdy_both), .gap_done(gap_done), .state_q(state_q),
    .state_nxt(state_nxt), .gap_clear(gap_clear)
  );

  io_rst_outreg u_out (
    .clk(clk), .rst_n(rst_n), .state_nxt(state_nxt),
    .cmp_off_req(cmp_off_req), .out_q(out_q)
  );

  assign dly_rst_o    = out_q.dly_rst;
  assign slc_rst_o    = out_q.slc_rst;
  assign ctl_rst_o    = out_q.ctl_rst;
  assign phy_clk_en_o = out_q.phy_en;
  assign cmp_en_o     = out_q.cmp_en;
  assign app_rst_o    = out_q.app_rst;
endmodule

// File: rtl/io_rst_seq_chk.sv
module io_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_rst,
  input logic cmp_off_req,
  input logic dly_rst_o,
  input logic slc_rst_o,
  input logic ctl_rst_o,
  input logic phy_clk_en_o,
  input logic cmp_en_o,
  input logic app_rst_o
);
  // R3: later groups never released ahead of earlier ones
  p_order_slc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slc_rst_o |-> !dly_rst_o);
  p_order_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rst_o |-> !slc_rst_o);
  // R4: PHY clock gated while any group is in reset
  p_phy_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_rst_o || slc_rst_o || ctl_rst_o) |-> !phy_clk_en_o);
  // R5: application released only with the PHY clock running
  p_app_after_phy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !app_rst_o |-> (phy_clk_en_o && !ctl_rst_o));
  // R6: compensation enable high while anything is held in reset
  p_cmp_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (app_rst_o || dly_rst_o || slc_rst_o || ctl_rst_o) |-> cmp_en_o);
  // R7: a request sampled after release drops the enable next cycle
  p_cmp_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!app_rst_o && cmp_off_req && !sys_rst) |=> !cmp_en_o);
  // R8: runtime reset asserts every group and gates the PHY clock
  p_runtime_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !(dly_rst_o && slc_rst_o && ctl_rst_o && app_rst_o && !phy_clk_en_o && !$past(app_rst_o && !phy_clk_en_o && dly_rst_o && !sys_rst)))
    |=> (dly_rst_o && slc_rst_o && ctl_rst_o && app_rst_o && !phy_clk_en_o && cmp_en_o));
endmodule

bind io_rst_seq io_rst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .cmp_off_req(cmp_off_req),
  .dly_rst_o(dly_rst_o), .slc_rst_o(slc_rst_o), .ctl_rst_o(ctl_rst_o),
  .phy_clk_en_o(phy_clk_en_o), .cmp_en_o(cmp_en_o), .app_rst_o(app_rst_o)
);

// File: tb/sim_io_rst_seq.sv
module sim_io_rst_seq;
  localparam int NS  = 2;
  localparam int GAP = 5;
  localparam int LIM = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_async = 1'b0;
  logic sys_rst = 1'b0;
  logic dly_rdy = 1'b0;
  logic cmp_rdy = 1'b0;
  logic cmp_off_req = 1'b0;
  logic dly_rst_o, slc_rst_o, ctl_rst_o, phy_clk_en_o, cmp_en_o, app_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  io_rst_seq #(.SYNC_STAGES(NS), .GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_async(lock_async), .sys_rst(sys_rst),
    .dly_rdy(dly_rdy), .cmp_rdy(cmp_rdy), .cmp_off_req(cmp_off_req),
    .dly_rst_o(dly_rst_o), .slc_rst_o(slc_rst_o), .ctl_rst_o(ctl_rst_o),
    .phy_clk_en_o(phy_clk_en_o), .cmp_en_o(cmp_en_o), .app_rst_o(app_rst_o)
  );

  // Expected delays, from the requirements
  function automatic int exp_lock_to_dly(int stages, int gap);
    return stages + gap + 1;
  endfunction
  function automatic int exp_rdy_to_app(int gap);
    return gap + 1;
  endfunction
  function automatic logic [5:0] held_pattern();
    return 6'b111011; // dly,slc,ctl,phy,cmp,app
  endfunction

  function automatic logic sig(int s);
    case (s)
      0: return dly_rst_o;
      1: return slc_rst_o;
      2: return ctl_rst_o;
      3: return phy_clk_en_o;
      4: return app_rst_o;
      default: return cmp_en_o;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_for(input int s, input logic v, output int n);
    n = 0;
    while (sig(s) !== v && n < LIM) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [5:0] outs();
    return {dly_rst_o, slc_rst_o, ctl_rst_o, phy_clk_en_o, cmp_en_o, app_rst_o};
  endfunction

  // Release steps after dly_rst_o has fallen; ready timing chosen by early_rdy
  task automatic finish_seq(input logic early_rdy, input int rdy_wait);
    int n;
    wait_for(1, 1'b0, n); chk(n == GAP, "R3 slice release gap", n, GAP);
    chk(ctl_rst_o == 1'b1, "R3 ctl held after slice", ctl_rst_o, 1);
    wait_for(2, 1'b0, n); chk(n == GAP, "R3 ctl release gap", n, GAP);
    chk(phy_clk_en_o == 1'b0, "R4 phy low at ctl release", phy_clk_en_o, 0);
    if (early_rdy) begin dly_rdy = 1'b1; cmp_rdy = 1'b1; end
    wait_for(3, 1'b1, n); chk(n == GAP, "R4 phy enable gap", n, GAP);
    if (early_rdy) begin
      wait_for(4, 1'b0, n);
      chk(n == exp_rdy_to_app(GAP), "R5 app release (ready early)", n, exp_rdy_to_app(GAP));
    end else begin
      cmp_off_req = 1'b1;
      idle(rdy_wait);
      chk(cmp_en_o == 1'b1, "R7 request ignored before release", cmp_en_o, 1);
      chk(app_rst_o == 1'b1, "R5 app held without ready", app_rst_o, 1);
      cmp_off_req = 1'b0;
      dly_rdy = 1'b1; cmp_rdy = 1'b1;
      wait_for(4, 1'b0, n);
      chk(n == exp_rdy_to_app(GAP), "R5 app release after ready", n, exp_rdy_to_app(GAP));
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    idle(3);
    chk(outs() == held_pattern(), "R1 reset state", outs(), held_pattern());
    rst_n = 1'b1;
    idle(15);
    chk(outs() == held_pattern(), "R1 waits for lock", outs(), held_pattern());

    // Power-up: ready flags raised late, one flag alone first
    lock_async = 1'b1;
    wait_for(0, 1'b0, n);
    chk(n == exp_lock_to_dly(NS, GAP), "R2 lock to delay-line release", n, exp_lock_to_dly(NS, GAP));
    chk(slc_rst_o == 1'b1, "R3 slice held after delay release", slc_rst_o, 1);
    chk(cmp_en_o == 1'b1, "R6 cmp high during sequence", cmp_en_o, 1);
    begin
      int k;
      wait_for(3, 1'b1, k);
      dly_rdy = 1'b1;
      idle(8);
      chk(app_rst_o == 1'b1, "R5 single ready flag insufficient", app_rst_o, 1);
      dly_rdy = 1'b0;
    end
    // continue (PHY already on): raise both
    dly_rdy = 1'b1; cmp_rdy = 1'b1;
    wait_for(4, 1'b0, n);
    chk(n == exp_rdy_to_app(GAP), "R5 app release after both ready", n, exp_rdy_to_app(GAP));

    // R7: honoured in run
    cmp_off_req = 1'b1; idle(1);
    chk(cmp_en_o == 1'b0, "R7 cmp drop in run", cmp_en_o, 0);
    cmp_off_req = 1'b0; idle(1);
    chk(cmp_en_o == 1'b1, "R7 cmp restore in run", cmp_en_o, 1);

    // Random runtime resets
    for (int it = 0; it < 12; it++) begin
      int len, rw;
      logic early, req;
      len   = 1 + int'($urandom_range(0, 20));
      rw    = 1 + int'($urandom_range(0, 15));
      early = 1'($urandom_range(0, 1));
      req   = 1'($urandom_range(0, 1));
      cmp_off_req = req;
      idle(int'($urandom_range(1, 6)));
      sys_rst = 1'b1; idle(1);
      chk(outs() == held_pattern(), "R8 runtime reset asserts all", outs(), held_pattern());
      lock_async = 1'($urandom_range(0, 1));
      dly_rdy = 1'b0; cmp_rdy = 1'b0; cmp_off_req = 1'b0;
      idle(len);
      chk(outs() == held_pattern(), "R8 held while request high", outs(), held_pattern());
      sys_rst = 1'b0;
      wait_for(0, 1'b0, n);
      chk(n == GAP, "R9 restart without lock", n, GAP);
      finish_seq(early, rw);
    end

    // Directed: runtime reset in mid-sequence (slice step)
    sys_rst = 1'b1; idle(2);
    dly_rdy = 1'b0; cmp_rdy = 1'b0;
    sys_rst = 1'b0;
    wait_for(0, 1'b0, n);
    chk(n == GAP, "R9 restart gap", n, GAP);
    idle(2);
    sys_rst = 1'b1; idle(1);
    chk(outs() == held_pattern(), "R8 mid-sequence reset", outs(), held_pattern());
    sys_rst = 1'b0;
    wait_for(0, 1'b0, n);
    chk(n == GAP, "R9 restart after mid-sequence reset", n, GAP);
    finish_seq(1'b0, 3);
    chk(cmp_en_o == 1'b1, "R6 cmp high after run entry", cmp_en_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule